// File: doc/BRIEF.md
# T1 Receive Frame Timing Generator

This block produces the bit-level and frame-level timing strobes for a recovered 1.544 MHz T1 receive stream. A framer upstream finds frame alignment and pulses `frame_start` on the framing bit of the first frame of a multiframe. From that point the block counts the 193 bit periods of each frame and the frames of each multiframe. It then drives a channel clock, a per-channel programmable block signal, a frame or multiframe sync pulse, and a low-rate link clock with its update strobe.

The configuration inputs are static. They select superframe (12 frames) or extended superframe (24 frames) counting, frame or multiframe sync, widened sync on signaling frames, the zero-byte link rate, and the 24-bit channel mask. All outputs are registered. The clock edge that samples `frame_start` high presents bit 0 of frame 0, and every later edge presents the next bit of the stream.

Top module: `t1_rx_timing`

## Requirements
- R1: A frame is 193 bits. Bit 0 is the framing bit, and channel c (0..23) occupies bits 1+8c through 8+8c with its most significant bit first. The edge that samples `frame_start` high shows bit 0 of frame 0 on the outputs, and each following edge advances one bit.
- R2: `chan_clk` is high for exactly one clock, on the last bit (bit 8+8c) of every channel. It is never high on the framing bit.
- R3: `chan_blk` equals `blk_mask[c]` for all 8 bits of channel c and is low on the framing bit.
- R4: After reset, and until the first `frame_start`, all five outputs stay low. An active-low synchronous reset returns the block to this state.
- R5: With `sync_mf`=0 and `sync_wide`=0, `sync_out` is high for one clock on bit 0 of every frame.
- R6: With `sync_mf`=0 and `sync_wide`=1, `sync_out` is also high on bit 1 of signaling frames. Signaling frames are frames whose 0-based index within the multiframe is 5, 11, 17 or 23.
- R7: With `esf_mode`=0, the frame index wraps from 11 to 0.
- R8: With `esf_mode`=1, the frame index wraps from 23 to 0.
- R9: With `sync_mf`=1, `sync_out` is high for one clock on bit 0 of frame 0 only, whatever the value of `sync_wide`.
- R10: With `zb_mode`=0, `link_clk` is high for the whole of every odd-indexed frame and low otherwise, giving 4 kHz.
- R11: With `zb_mode`=1, `link_clk` is high during frames whose index mod 4 is 3 or 0 and low otherwise, giving 2 kHz.
- R12: `link_upd` is high for one clock on bit 192 of the frame just before each frame in which `link_clk` rises. These are even frames when `zb_mode`=0, and frames with index mod 4 equal to 2 when `zb_mode`=1.
- R13: A `frame_start` pulse in the middle of a frame realigns the counters, so the next edge shows bit 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Alignment reference: current bit is bit 0 of frame 0 |
| esf_mode | input | 1 | 1 = 24-frame multiframe, 0 = 12-frame |
| sync_mf | input | 1 | 1 = sync marks multiframes, 0 = frames |
| sync_wide | input | 1 | Widen frame sync to two clocks on signaling frames |
| zb_mode | input | 1 | 1 = 2 kHz link clock, 0 = 4 kHz |
| blk_mask | input | 24 | Channel-block level per channel, bit c = channel c |
| chan_clk | output | 1 | Last-bit strobe of each channel |
| chan_blk | output | 1 | Programmed channel-block level |
| sync_out | output | 1 | Frame or multiframe sync pulse |
| link_clk | output | 1 | Link clock |
| link_upd | output | 1 | Link data update strobe, one clock before a link frame |

## Verification
The bench walks several whole multiframes in each mode and compares every output on every bit against a position model. This catches an off-by-one channel boundary, which would put `chan_clk` on a channel's first bit or spill a channel's mask level into its neighbour, and a framing-bit leak into `chan_blk`. Runs of 26 and 50 frames cross the 12- and 24-frame wraps, so a wrong multiframe length shows up as a misplaced multiframe sync or widened pulse. A mid-frame realignment and a reset taken while the block is running check that the counters restart rather than continue, and that no strobe appears before the first alignment. The zero-byte runs check that the link clock halves its rate and that the update strobe moves to the matching frames.

// File: rtl/t1_rx_timing.sv
module t1_rx_timing #(
  parameter int NCH        = 24,
  parameter int CHBITS     = 8,
  parameter int SF_FRAMES  = 12,
  parameter int ESF_FRAMES = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           esf_mode,
  input  logic           sync_mf,
  input  logic           sync_wide,
  input  logic           zb_mode,
  input  logic [NCH-1:0] blk_mask,
  output logic           chan_clk,
  output logic           chan_blk,
  output logic           sync_out,
  output logic           link_clk,
  output logic           link_upd
);
  localparam int FBITS = 1 + NCH * CHBITS;
  localparam int BIT_W = $clog2(FBITS);
  localparam int FRM_W = $clog2(ESF_FRAMES);
  localparam int CH_W  = $clog2(CHBITS);
  localparam int IDX_W = $clog2(NCH);
  localparam int SIG_A = SF_FRAMES / 2 - 1;
  localparam int SIG_B = SF_FRAMES - 1;

  logic [BIT_W-1:0] bit_q, cur_bit, bm1;
  logic [FRM_W-1:0] frm_q, cur_frm, mf_last;
  logic             aln_q, live;
  logic [IDX_W-1:0] ch_idx;
  logic [1:0]       m4;
  logic             sig_frm, is_lsb, blk_n, sync_n, lclk_n, lupd_n;

  assign cur_bit = frame_start ? '0 : bit_q;
  assign cur_frm = frame_start ? '0 : frm_q;
  assign live    = aln_q | frame_start;
  assign mf_last = esf_mode ? FRM_W'(ESF_FRAMES - 1) : FRM_W'(SF_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      frm_q <= '0;
      aln_q <= 1'b0;
    end else if (frame_start) begin
      bit_q <= BIT_W'(1);
      frm_q <= '0;
      aln_q <= 1'b1;
    end else if (aln_q) begin
      if (bit_q == BIT_W'(FBITS - 1)) begin
        bit_q <= '0;
        frm_q <= (frm_q >= mf_last) ? '0 : frm_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign bm1     = cur_bit - 1'b1;
  assign ch_idx  = IDX_W'(bm1 >> CH_W);
  assign is_lsb  = (cur_bit != '0) && (cur_bit[CH_W-1:0] == '0);
  assign blk_n   = (cur_bit != '0) && blk_mask[ch_idx];
  assign sig_frm = ((32'(cur_frm) % SF_FRAMES) == SIG_A) ||
                   ((32'(cur_frm) % SF_FRAMES) == SIG_B);
  assign sync_n  = sync_mf ? (cur_bit == '0 && cur_frm == '0)
                           : (cur_bit == '0) ||
                             (sync_wide && sig_frm && cur_bit == BIT_W'(1));
  assign m4      = cur_frm[1:0];
  assign lclk_n  = zb_mode ? (m4 == 2'd3 || m4 == 2'd0) : cur_frm[0];
  assign lupd_n  = (cur_bit == BIT_W'(FBITS - 1)) &&
                   (zb_mode ? (m4 == 2'd2) : !cur_frm[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_clk <= 1'b0;
      chan_blk <= 1'b0;
      sync_out <= 1'b0;
      link_clk <= 1'b0;
      link_upd <= 1'b0;
    end else begin
      chan_clk <= live & is_lsb;
      chan_blk <= live & blk_n;
      sync_out <= live & sync_n;
      link_clk <= live & lclk_n;
      link_upd <= live & lupd_n;
    end
  end
endmodule

module t1_rx_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic sync_mf,
  input logic sync_wide,
  input logic chan_clk,
  input logic chan_blk,
  input logic sync_out,
  input logic link_clk,
  input logic link_upd
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (frame_start) seen <= 1'b1;
  end

  AST_CHCLK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk |=> !chan_clk); // R2
  AST_QUIET_BEFORE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !(chan_clk | chan_blk | sync_out | link_clk | link_upd)); // R4
  AST_NARROW_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mf && !sync_wide && sync_out && !frame_start) |=> !sync_out); // R5
  AST_MF_SYNC_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mf && sync_out && !frame_start) |=> !sync_out); // R9
  AST_LINK_UPD_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_upd && !frame_start) |=> $rose(link_clk)); // R12
  AST_REALIGN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> sync_out); // R13
endmodule

bind t1_rx_timing t1_rx_timing_chk u_chk (.*);

// File: tb/t1_rx_timing_bench.sv
module t1_rx_timing_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, frame_start = 1'b0;
  logic esf_mode = 1'b0, sync_mf = 1'b0, sync_wide = 1'b0, zb_mode = 1'b0;
  logic [23:0] blk_mask = '0;
  logic chan_clk, chan_blk, sync_out, link_clk, link_upd;
  int n_cmp = 0, n_bad = 0;

  t1_rx_timing u_t1_rx_timing (.*);

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; frame_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic align();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic walk(int nbits, string tag);
    int b = 0, f = 0;
    for (int i = 0; i < nbits; i++) begin
      int mfl = esf_mode ? 24 : 12;
      logic e_cc  = (b >= 8) && (b % 8 == 0);
      logic e_blk = (b >= 1) && blk_mask[(b - 1) / 8];
      logic e_sy  = sync_mf ? (b == 0 && f == 0)
                            : (b == 0 || (sync_wide && b == 1 && (f % 12 == 5 || f % 12 == 11)));
      logic e_lc  = zb_mode ? (f % 4 == 3 || f % 4 == 0) : (f % 2 == 1);
      logic e_lu  = (b == 192) && (zb_mode ? (f % 4 == 2) : (f % 2 == 0));
      chk({"R2 chan_clk ", tag}, chan_clk, e_cc);
      chk({"R3 chan_blk ", tag}, chan_blk, e_blk);
      chk({sync_mf ? "R9" : "R5/R6", " sync_out ", tag}, sync_out, e_sy);
      chk({zb_mode ? "R11" : "R10", " link_clk ", tag}, link_clk, e_lc);
      chk({"R12 link_upd ", tag}, link_upd, e_lu);
      @(negedge clk);
      b++;
      if (b == 193) begin b = 0; f = (f + 1) % mfl; end
    end
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) begin
      chk({"R4 idle ", tag}, chan_clk | chan_blk | sync_out | link_clk | link_upd, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    quiet(400, "before first alignment");
    align();
    walk(50, "R1 short run");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    quiet(250, "after mid-run reset");
  endtask

  task automatic t_sf();
    esf_mode = 0; sync_mf = 0; sync_wide = 0; zb_mode = 0; blk_mask = 24'hA5C31E;
    do_reset(); align();
    walk(26 * 193, "R1 R7 superframe narrow");
  endtask

  task automatic t_esf_wide();
    esf_mode = 1; sync_mf = 0; sync_wide = 1; zb_mode = 0; blk_mask = 24'h800001;
    do_reset(); align();
    walk(50 * 193, "R6 R8 extended wide");
  endtask

  task automatic t_mf();
    esf_mode = 0; sync_mf = 1; sync_wide = 1; zb_mode = 0; blk_mask = 24'hFFFFFF;
    do_reset(); align();
    walk(26 * 193, "R9 R7 multiframe sync");
    esf_mode = 1;
    do_reset(); align();
    walk(50 * 193, "R9 R8 multiframe sync");
  endtask

  task automatic t_zb();
    esf_mode = 0; sync_mf = 0; sync_wide = 1; zb_mode = 1; blk_mask = 24'h0F00F0;
    do_reset(); align();
    walk(26 * 193, "R11 R12 zero-byte superframe");
    esf_mode = 1; blk_mask = 24'h000000;
    do_reset(); align();
    walk(50 * 193, "R11 R12 zero-byte extended");
  endtask

  task automatic t_realign();
    esf_mode = 1; sync_mf = 0; sync_wide = 0; zb_mode = 0; blk_mask = 24'h3C3C3C;
    do_reset(); align();
    walk(3 * 193 + 77, "R13 before realign");
    align();
    chk("R13 sync right after realign", sync_out, 1'b1);
    walk(4 * 193, "R13 after realign");
  endtask

  initial begin
    t_reset();
    t_sf();
    t_esf_wide();
    t_mf();
    t_zb();
    t_realign();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule